// File: doc/BRIEF.md
# UART Character Buffer with Queue/Hold Modes

This block buffers characters between a CPU-facing data register and the serial engines of a UART. Bytes the CPU writes are queued for the transmitter. Characters arriving from the receiver are queued for the CPU, and each one carries framing, parity and break flags, plus an overrun flag that the buffer sets itself. A mode input selects between a 32-entry queue in each direction and a single-entry hold register in each direction.

The CPU side uses a write strobe with a byte, and a read strobe that pops the oldest receive entry in the same access. The read word is valid whenever an entry is present. The transmitter sees a byte with a valid flag and takes it with a pop strobe. The receiver delivers a character and its three line-error flags with a push strobe. Four level flags report full and empty for each direction.

Top module: `uart_data_buffer`

## Requirements
- R1: In queue mode (`fifo_en`=1) the transmit side holds up to 32 bytes and offers them in write order. A byte written into an empty buffer appears on `tx_data` with `tx_valid` high in the cycle after the write edge.
- R2: In hold mode (`fifo_en`=0) the transmit side holds at most one byte.
- R3: In queue mode the receive side holds up to 32 entries, returned in arrival order. Each entry is 12 bits: bits 7:0 are the character, bit 8 is framing error (`rx_err[0]`), bit 9 is parity error (`rx_err[1]`), bit 10 is break error (`rx_err[2]`), and bit 11 is overrun.
- R4: In hold mode the receive side holds at most one entry.
- R5: `tx_full`/`rx_full` are high when the occupancy equals the capacity of the current mode (32 or 1). `tx_empty`/`rx_empty` are high when the occupancy is zero.
- R6: A CPU write while the transmit side is full is discarded. The stored bytes and their order are unchanged.
- R7: A receiver push while the receive side is full is dropped, and bit 11 of the most recently stored entry is set.
- R8: `cpu_rdata` shows the oldest receive entry, and a `cpu_rd` pops it. When the receive side is empty, `cpu_rdata` reads zero and `cpu_rd` changes nothing.
- R9: A change of `fifo_en` empties both directions at the next edge. Any strobe in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = 32-entry queue mode, 0 = hold-register mode |
| cpu_wr | input | 1 | Data-register write strobe |
| cpu_wdata | input | 8 | Byte to transmit |
| cpu_rd | input | 1 | Data-register read strobe (pops) |
| cpu_rdata | output | 12 | Oldest receive entry, zero when empty |
| tx_full | output | 1 | Transmit side full |
| tx_empty | output | 1 | Transmit side empty |
| rx_full | output | 1 | Receive side full |
| rx_empty | output | 1 | Receive side empty |
| tx_valid | output | 1 | A byte is offered to the transmitter |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_pop | input | 1 | Transmitter takes the offered byte |
| rx_push | input | 1 | Receiver delivers a character |
| rx_data | input | 8 | Received character |
| rx_err | input | 3 | {break, parity, framing} flags for the character |

## Verification
The bench drives the buffer with random traffic whose bias swings between filling and draining, so both directions repeatedly hit full and empty in each mode. It targets:
- Writes into a full transmit side. A design that accepted them would overwrite a queued byte or corrupt the order.
- Pushes into a full receive side. A design that handled these wrongly would lose the overrun mark, place it on the wrong entry, or store the new character.
- Reads of an empty receive side. A design that got these wrong would return stale data or move its pointers.
- Mode switches made with data still queued. A design that did not flush would leak old bytes or report the wrong hold-mode capacity.

// File: rtl/uart_data_buffer.sv
module uart_data_buffer #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  output logic [DW+3:0] cpu_rdata,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          rx_empty,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_pop,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  input  logic [2:0]    rx_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int RW = DW + 4;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic          en_q;
  logic [CW-1:0] cap;
  wire flush = fifo_en ^ en_q;
  assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

  logic [DW-1:0] tmem [DEPTH];
  logic [AW-1:0] twp, trp;
  logic [CW-1:0] tcnt;
  assign tx_full  = tcnt == cap;
  assign tx_empty = tcnt == '0;
  assign tx_valid = !tx_empty;
  assign tx_data  = tmem[trp];
  wire t_in  = cpu_wr && !tx_full && !flush;
  wire t_out = tx_pop && !tx_empty && !flush;

  logic [RW-1:0] rmem [DEPTH];
  logic [AW-1:0] rwp, rrp;
  logic [CW-1:0] rcnt;
  assign rx_full   = rcnt == cap;
  assign rx_empty  = rcnt == '0;
  assign cpu_rdata = rx_empty ? '0 : rmem[rrp];
  wire r_in  = rx_push && !rx_full && !flush;
  wire r_ovr = rx_push && rx_full && !flush;
  wire r_out = cpu_rd && !rx_empty && !flush;
  wire [AW-1:0] rlast = (rwp == '0) ? AW'(DEPTH - 1) : rwp - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;

  always_ff @(posedge clk) begin
    if (t_in) tmem[twp] <= cpu_wdata;
    if (r_in) rmem[rwp] <= {1'b0, rx_err, rx_data};
    if (r_ovr) rmem[rlast][RW-1] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else if (flush) begin
      twp <= '0; trp <= '0; tcnt <= '0;
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (t_in)  twp <= inc(twp);
      if (t_out) trp <= inc(trp);
      tcnt <= tcnt + CW'(t_in) - CW'(t_out);
      if (r_in)  rwp <= inc(rwp);
      if (r_out) rrp <= inc(rrp);
      rcnt <= rcnt + CW'(r_in) - CW'(r_out);
    end
  end

  assert_tx_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> tcnt <= cap);
  assert_rx_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> rcnt <= cap);
  assert_drop_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && tx_full && !tx_pop && !flush |=> $stable(tcnt));
  assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full && !cpu_rd && !flush |=> $stable(rcnt) && $stable(rwp));
  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && rx_empty && !rx_push |=> rx_empty && $stable(rrp));
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> tx_empty && rx_empty);
endmodule

// File: tb/tb_uart_data_buffer.sv
module tb_uart_data_buffer;
  logic clk = 0, rst_n = 0, fifo_en = 1;
  logic cpu_wr = 0, cpu_rd = 0, tx_pop = 0, rx_push = 0;
  logic [7:0] cpu_wdata = 0, rx_data = 0, tx_data;
  logic [2:0] rx_err = 0;
  logic [11:0] cpu_rdata;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_valid;
  int checks = 0, errors = 0;
  logic [7:0] tq[$];
  logic [11:0] rq[$];
  bit flushed = 0;

  always #2 clk = ~clk;

  uart_data_buffer dut (.clk, .rst_n, .fifo_en, .cpu_wr, .cpu_wdata, .cpu_rd,
    .cpu_rdata, .tx_full, .tx_empty, .rx_full, .rx_empty, .tx_valid, .tx_data,
    .tx_pop, .rx_push, .rx_data, .rx_err);

  function automatic int cap_now();
    return fifo_en ? 32 : 1;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    string fl = flushed ? "R9" : "R5";
    string tt = fifo_en ? "R1" : "R2";
    chk(tx_empty, tq.size() == 0, fl);
    chk(tx_full, tq.size() == cap_now(), fl);
    chk(rx_empty, rq.size() == 0, fl);
    chk(rx_full, rq.size() == cap_now(), fl);
    chk(tx_valid, tq.size() != 0, tt);
    if (tq.size() != 0) chk(tx_data, tq[0], tq.size() == cap_now() ? "R6" : tt);
    if (rq.size() == 0) chk(cpu_rdata, 0, "R8");
    else chk(cpu_rdata, rq[0], rq[0][11] ? "R7" : (fifo_en ? "R3" : "R4"));
    flushed = 0;
  endtask

  task automatic step(input bit w, input bit r, input bit tp, input bit rp);
    bit tin, tout, rin, rovr, rout;
    logic [7:0] wd = 8'($urandom);
    logic [7:0] rd = 8'($urandom);
    logic [2:0] re = 3'($urandom);
    @(negedge clk);
    check_outputs();
    cpu_wr = w; cpu_wdata = wd; cpu_rd = r; tx_pop = tp;
    rx_push = rp; rx_data = rd; rx_err = re;
    tin  = w && tq.size() < cap_now();
    tout = tp && tq.size() > 0;
    rin  = rp && rq.size() < cap_now();
    rovr = rp && rq.size() == cap_now();
    rout = r && rq.size() > 0;
    @(posedge clk);
    if (rovr) rq[rq.size()-1][11] = 1'b1;
    if (tout) void'(tq.pop_front());
    if (rout) void'(rq.pop_front());
    if (tin) tq.push_back(wd);
    if (rin) rq.push_back({1'b0, re, rd});
  endtask

  task automatic toggle_mode();
    @(negedge clk);
    check_outputs();
    cpu_wr = 0; cpu_rd = 0; tx_pop = 0; rx_push = 0;
    fifo_en = ~fifo_en;
    @(posedge clk);
    tq.delete(); rq.delete();
    flushed = 1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step(0, 0, 0, 0);
    // R6 / R7: overfill both sides in queue mode
    for (int i = 0; i < 36; i++) step(1, 0, 0, 1);
    // R8: drain, then read while empty
    for (int i = 0; i < 36; i++) step(0, 1, 1, 0);
    step(0, 1, 0, 0);
    // R2 / R4 hold mode with refused writes and pushes
    toggle_mode();
    for (int i = 0; i < 4; i++) step(1, 0, 0, 1);
    step(0, 1, 1, 0);
    step(0, 1, 0, 0);
    // R9: switch back with data pending
    step(1, 0, 0, 1);
    toggle_mode();
    for (int ph = 0; ph < 40; ph++) begin
      int pin = (ph % 2) ? 80 : 25;
      int pout = (ph % 2) ? 25 : 80;
      if (ph % 7 == 6) toggle_mode();
      for (int c = 0; c < 100; c++)
        step($urandom_range(99) < pin, $urandom_range(99) < pout,
             $urandom_range(99) < pout, $urandom_range(99) < pin);
    end
    step(0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule